// File: doc/BRIEF.md
# Bus-Attached Multiply-Accumulate Unit

This block is a word-wide multiplier peripheral that sits on a small synchronous register bus of a 16-bit controller. It has two independent sections. The narrow section multiplies two 16-bit operands. The wide section multiplies two 32-bit operands, each loaded as two halves. Software chooses the operation by the address it writes the first operand to. Writing the second operand (in the wide section, its upper half) starts the computation. The result is then read back as 16-bit words.

The narrow section has four modes: unsigned product, signed product, unsigned accumulate and signed accumulate. A sum-extension word tells software the sign of the signed result or of the signed accumulator. Writing the low result word preloads the accumulator, so a dot product can start from a chosen bias. The wide section offers an unsigned and a signed 64-bit product.

Word address map (`bus_addr`, word offsets): 0x00 unsigned-product operand A, 0x01 signed-product operand A, 0x02 unsigned-accumulate operand A, 0x03 signed-accumulate operand A, 0x04 operand B (trigger), 0x05 result low (read/preload), 0x06 result high, 0x07 sum extension, 0x08 wide A low (unsigned), 0x09 wide A low (signed), 0x0A wide A high, 0x0B wide B low, 0x0C wide B high (trigger), 0x0D to 0x10 wide result words 0 (least significant) to 3.

Top module: `mpy_periph`

## Requirements
- R1: A write to offset 0x00, 0x01, 0x02 or 0x03 latches operand A and selects, in that order, unsigned product, signed product, unsigned accumulate or signed accumulate. Reading any of these offsets returns operand A. Reading 0x04 returns operand B.
- R2: A write to 0x04 latches operand B and runs the mode chosen by the most recent operand-A write, using the new operand B. A read issued in the cycle after the write sees the new result. `bus_rdata` changes on the clock edge that samples the read, and holds its value when no read is issued.
- R3: The product modes load the full 32-bit product into the result and clear the accumulator. The accumulate modes add the product to the 32-bit accumulator (modulo 2^32), and the sum becomes both accumulator and result. 0x05 reads result bits 15:0 and 0x06 reads bits 31:16.
- R4: The signed modes treat both 16-bit operands as two's complement. The unsigned modes treat them as unsigned.
- R5: Offset 0x07 returns 0xFFFF when result bit 31 is set in signed-product mode, or when accumulator bit 31 is set in signed-accumulate mode. In every other case it returns 0x0000, and this includes both unsigned modes.
- R6: A write to 0x05 sets both result and accumulator to the written word. The word is zero-extended in the unsigned modes and sign-extended in the signed modes.
- R7: A write to 0x08 (unsigned) or 0x09 (signed) sets wide operand A to the written word with bits 31:16 cleared, and selects the wide mode. A write to 0x0A replaces bits 31:16 and keeps bits 15:0. For operand B, 0x0B and 0x0C behave in the same way. Offsets 0x08/0x09, 0x0A, 0x0B and 0x0C read back these halves.
- R8: A write to 0x0C runs a 64x-bit product of wide A and the updated wide B, unsigned or signed as selected. It is read at 0x0D to 0x10, least significant word first. A write to 0x0B leaves the wide result unchanged.
- R9: Reads of offsets above 0x10 return 0. Writes to read-only or unmapped offsets change no readable state.
- R10: Synchronous active-high reset clears all operands, results, the accumulator, both modes (narrow unsigned product, wide unsigned) and `bus_rdata`.
- R11: When read and write are issued in the same cycle at the same offset, the read returns the value from before that write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Word offset |
| bus_wdata | input | W (16) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | W (16) | Registered read data |

## Verification
A read and a write can fall in the same cycle at the same offset. The bench provokes this in three places: at the result-low offset, where it meets an accumulator preload; at operand B, where it meets a trigger; and at the wide B upper half, where it meets a wide trigger. In each case the returned word must equal the reference model's value from before the write. Follow-up reads must then show the state after the write. Constrained random sequences that mix mode changes, preloads and triggers cover the operation paths, and directed extremes (0x8000, 0xFFFF, accumulator wrap) cover the sign and carry corners.

// File: rtl/mpy_pkg.sv
package mpy_pkg;

  typedef enum logic [1:0] {
    M_UMUL = 2'd0,
    M_SMUL = 2'd1,
    M_UMAC = 2'd2,
    M_SMAC = 2'd3
  } mode16_t;

  localparam int OFS_A16   = 0;
  localparam int OFS_B16   = 4;
  localparam int OFS_RLO   = 5;
  localparam int OFS_RHI   = 6;
  localparam int OFS_SEXT  = 7;
  localparam int OFS_XLO_U = 8;
  localparam int OFS_XLO_S = 9;
  localparam int OFS_XHI   = 10;
  localparam int OFS_YLO   = 11;
  localparam int OFS_YHI   = 12;
  localparam int OFS_WRES  = 13;
  localparam int NUM_WRES  = 4;
  localparam int OFS_LAST  = OFS_WRES + NUM_WRES - 1;

  typedef struct packed {
    logic    wr_a;
    mode16_t a_mode;
    logic    wr_b;
    logic    wr_rlo;
    logic    wr_xlo;
    logic    x_signed;
    logic    wr_xhi;
    logic    wr_ylo;
    logic    wr_yhi;
  } wstb_t;

endpackage

// File: rtl/mpy_decode.sv
module mpy_decode
  import mpy_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wstb_t             stb
);

  localparam int NUM_A = 4;

  logic [NUM_A-1:0] hit_a;

  genvar g;
  generate
    for (g = 0; g < NUM_A; g++) begin : g_op1
      assign hit_a[g] = we && (addr == ADDR_W'(OFS_A16 + g));
    end
  endgenerate

  always_comb begin
    stb          = '0;
    stb.wr_a     = |hit_a;
    stb.a_mode   = M_UMUL;
    for (int i = 0; i < NUM_A; i++) begin
      if (hit_a[i]) stb.a_mode = mode16_t'(i);
    end
    stb.wr_b     = we && (addr == ADDR_W'(OFS_B16));
    stb.wr_rlo   = we && (addr == ADDR_W'(OFS_RLO));
    stb.wr_xlo   = we && ((addr == ADDR_W'(OFS_XLO_U)) || (addr == ADDR_W'(OFS_XLO_S)));
    stb.x_signed = (addr == ADDR_W'(OFS_XLO_S));
    stb.wr_xhi   = we && (addr == ADDR_W'(OFS_XHI));
    stb.wr_ylo   = we && (addr == ADDR_W'(OFS_YLO));
    stb.wr_yhi   = we && (addr == ADDR_W'(OFS_YHI));
  end

  // R1: at most one register is written per cycle
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.wr_a, stb.wr_b, stb.wr_rlo, stb.wr_xlo, stb.wr_xhi, stb.wr_ylo, stb.wr_yhi}));

endmodule

// File: rtl/mpy_sec16.sv
module mpy_sec16
  import mpy_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_a,
  input  mode16_t       a_mode,
  input  logic          wr_b,
  input  logic          wr_rlo,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  a_q,
  output logic [W-1:0]  b_q,
  output logic [2*W-1:0] res_q,
  output logic [W-1:0]  sumext
);

  localparam int PW = 2 * W;

  mode16_t       mode_q;
  logic [PW-1:0] acc_q;
  logic          sgn;
  logic          mac;
  logic [PW-1:0] opa_ext;
  logic [PW-1:0] opb_ext;
  logic [PW-1:0] prod;
  logic [PW-1:0] acc_sum;
  logic [PW-1:0] preload;

  assign sgn     = (mode_q == M_SMUL) || (mode_q == M_SMAC);
  assign mac     = (mode_q == M_UMAC) || (mode_q == M_SMAC);
  assign opa_ext = sgn ? {{W{a_q[W-1]}}, a_q}     : {{W{1'b0}}, a_q};
  assign opb_ext = sgn ? {{W{wdata[W-1]}}, wdata} : {{W{1'b0}}, wdata};
  // low PW bits of the extended product equal the exact signed/unsigned product
  assign prod    = opa_ext * opb_ext;
  assign acc_sum = acc_q + prod;
  assign preload = sgn ? {{W{wdata[W-1]}}, wdata} : {{W{1'b0}}, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= M_UMUL;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      if (wr_a) begin
        a_q    <= wdata;
        mode_q <= a_mode;
      end
      if (wr_b) begin
        b_q <= wdata;
        if (mac) begin
          acc_q <= acc_sum;
          res_q <= acc_sum;
        end else begin
          acc_q <= '0;
          res_q <= prod;
        end
      end
      if (wr_rlo) begin
        acc_q <= preload;
        res_q <= preload;
      end
    end
  end

  always_comb begin
    case (mode_q)
      M_SMUL:  sumext = {W{res_q[PW-1]}};
      M_SMAC:  sumext = {W{acc_q[PW-1]}};
      default: sumext = '0;
    endcase
  end

  // R1: operand-A write selects the mode for later triggers
  p_mode_latch_r1: assert property (@(posedge clk) disable iff (rst)
    wr_a |=> (mode_q == $past(a_mode)));

  // R3: product modes clear the accumulator
  p_mul_clears_acc_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_b && !mac) |=> (acc_q == '0));

  // R3: accumulate modes leave result equal to accumulator
  p_mac_res_acc_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_b && mac) |=> (res_q == acc_q));

  // R6: unsigned preload zero-extends
  p_preload_zext_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_rlo && !sgn) |=> (res_q[PW-1:W] == '0));

  // R6: signed preload of a negative word sign-extends
  p_preload_sext_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_rlo && sgn && wdata[W-1]) |=> (res_q[PW-1:W] == '1));

endmodule

// File: rtl/mpy_sec32.sv
module mpy_sec32 #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_xlo,
  input  logic           x_signed,
  input  logic           wr_xhi,
  input  logic           wr_ylo,
  input  logic           wr_yhi,
  input  logic [W-1:0]   wdata,
  output logic [2*W-1:0] x_q,
  output logic [2*W-1:0] y_q,
  output logic [4*W-1:0] r_q
);

  localparam int XW = 2 * W;
  localparam int RW = 4 * W;

  logic          s_q;
  logic [XW-1:0] y_new;
  logic [RW-1:0] xe;
  logic [RW-1:0] ye;
  logic [RW-1:0] prod;

  assign y_new = {wdata, y_q[W-1:0]};
  assign xe    = s_q ? {{XW{x_q[XW-1]}}, x_q}     : {{XW{1'b0}}, x_q};
  assign ye    = s_q ? {{XW{y_new[XW-1]}}, y_new} : {{XW{1'b0}}, y_new};
  assign prod  = xe * ye;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      s_q <= 1'b0;
      r_q <= '0;
    end else begin
      if (wr_xlo) begin
        x_q <= {{W{1'b0}}, wdata};
        s_q <= x_signed;
      end
      if (wr_xhi) x_q[XW-1:W] <= wdata;
      if (wr_ylo) y_q <= {{W{1'b0}}, wdata};
      if (wr_yhi) begin
        y_q <= y_new;
        r_q <= prod;
      end
    end
  end

  // R7: upper-half write keeps the lower half
  p_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (rst)
    wr_xhi |=> (x_q[W-1:0] == $past(x_q[W-1:0])));

  // R7: lower-half write clears the upper half
  p_lo_clears_hi_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ylo |=> (y_q[XW-1:W] == '0));

  // R8: lower half of B does not start a product
  p_ylo_no_trigger_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ylo && !wr_yhi) |=> $stable(r_q));

endmodule

// File: rtl/mpy_periph.sv
module mpy_periph
  import mpy_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [W-1:0]      bus_rdata
);

  localparam int PW = 2 * W;
  localparam int RW = 4 * W;

  wstb_t          stb;
  logic [W-1:0]   a_q;
  logic [W-1:0]   b_q;
  logic [PW-1:0]  res_q;
  logic [W-1:0]   sumext;
  logic [PW-1:0]  x_q;
  logic [PW-1:0]  y_q;
  logic [RW-1:0]  r_q;
  logic [W-1:0]   rd_mux;
  logic           mapped;

  mpy_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk  (clk),
    .rst  (rst),
    .addr (bus_addr),
    .we   (bus_we),
    .stb  (stb)
  );

  mpy_sec16 #(.W(W)) u_s16 (
    .clk    (clk),
    .rst    (rst),
    .wr_a   (stb.wr_a),
    .a_mode (stb.a_mode),
    .wr_b   (stb.wr_b),
    .wr_rlo (stb.wr_rlo),
    .wdata  (bus_wdata),
    .a_q    (a_q),
    .b_q    (b_q),
    .res_q  (res_q),
    .sumext (sumext)
  );

  mpy_sec32 #(.W(W)) u_s32 (
    .clk      (clk),
    .rst      (rst),
    .wr_xlo   (stb.wr_xlo),
    .x_signed (stb.x_signed),
    .wr_xhi   (stb.wr_xhi),
    .wr_ylo   (stb.wr_ylo),
    .wr_yhi   (stb.wr_yhi),
    .wdata    (bus_wdata),
    .x_q      (x_q),
    .y_q      (y_q),
    .r_q      (r_q)
  );

  assign mapped = (bus_addr <= ADDR_W'(OFS_LAST));

  always_comb begin
    rd_mux = '0;
    if (bus_addr < ADDR_W'(OFS_B16))                rd_mux = a_q;
    else if (bus_addr == ADDR_W'(OFS_B16))          rd_mux = b_q;
    else if (bus_addr == ADDR_W'(OFS_RLO))          rd_mux = res_q[W-1:0];
    else if (bus_addr == ADDR_W'(OFS_RHI))          rd_mux = res_q[PW-1:W];
    else if (bus_addr == ADDR_W'(OFS_SEXT))         rd_mux = sumext;
    else if ((bus_addr == ADDR_W'(OFS_XLO_U)) ||
             (bus_addr == ADDR_W'(OFS_XLO_S)))      rd_mux = x_q[W-1:0];
    else if (bus_addr == ADDR_W'(OFS_XHI))          rd_mux = x_q[PW-1:W];
    else if (bus_addr == ADDR_W'(OFS_YLO))          rd_mux = y_q[W-1:0];
    else if (bus_addr == ADDR_W'(OFS_YHI))          rd_mux = y_q[PW-1:W];
    else begin
      for (int k = 0; k < NUM_WRES; k++) begin
        if (bus_addr == ADDR_W'(OFS_WRES + k)) rd_mux = r_q[k*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !mapped) |=> (bus_rdata == '0));

  // R2: read data holds while no read is issued
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_re && !$past(rst)) |=> $stable(bus_rdata));

endmodule

// File: tb/mpy_periph_test.sv
`timescale 1ns/1ps
module mpy_periph_test;

  localparam int AW = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mpy_periph #(.ADDR_W(AW), .W(DW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  // reference model state
  logic [15:0] m_a, m_b;
  int          m_mode;
  logic [31:0] m_res, m_acc;
  logic [31:0] m_x, m_y;
  bit          m_s64;
  logic [63:0] m_r;

  task automatic m_reset();
    m_a = 0; m_b = 0; m_mode = 0; m_res = 0; m_acc = 0;
    m_x = 0; m_y = 0; m_s64 = 0; m_r = 0;
  endtask

  function automatic logic [31:0] prod16(logic [15:0] a, logic [15:0] b, bit s);
    longint pa, pb;
    pa = s ? longint'($signed(a)) : longint'(a);
    pb = s ? longint'($signed(b)) : longint'(b);
    return 32'(pa * pb);
  endfunction

  function automatic logic [63:0] prod32(logic [31:0] a, logic [31:0] b, bit s);
    logic [63:0] ua, ub;
    if (s) return 64'(longint'($signed(a)) * longint'($signed(b)));
    ua = {32'd0, a}; ub = {32'd0, b};
    return ua * ub;
  endfunction

  task automatic m_write(int ad, logic [15:0] d);
    bit s;
    s = (m_mode == 1) || (m_mode == 3);
    case (ad)
      0, 1, 2, 3: begin m_a = d; m_mode = ad; end
      4: begin
        m_b = d;
        if (m_mode >= 2) begin m_acc = m_acc + prod16(m_a, d, s); m_res = m_acc; end
        else begin m_res = prod16(m_a, d, s); m_acc = 0; end
      end
      5: begin m_res = s ? {{16{d[15]}}, d} : {16'd0, d}; m_acc = m_res; end
      8, 9: begin m_x = {16'd0, d}; m_s64 = (ad == 9); end
      10: m_x[31:16] = d;
      11: m_y = {16'd0, d};
      12: begin m_y[31:16] = d; m_r = prod32(m_x, m_y, m_s64); end
      default: ;
    endcase
  endtask

  function automatic logic [15:0] m_read(int ad);
    case (ad)
      0, 1, 2, 3: return m_a;
      4: return m_b;
      5: return m_res[15:0];
      6: return m_res[31:16];
      7: return (m_mode == 1) ? {16{m_res[31]}} : (m_mode == 3) ? {16{m_acc[31]}} : 16'h0;
      8, 9: return m_x[15:0];
      10: return m_x[31:16];
      11: return m_y[15:0];
      12: return m_y[31:16];
      13: return m_r[15:0];
      14: return m_r[31:16];
      15: return m_r[47:32];
      16: return m_r[63:48];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ad, logic [15:0] d);
    @(negedge clk);
    bus_addr = AW'(ad); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    m_write(ad, d);
  endtask

  task automatic rd(int ad, string req);
    logic [15:0] e;
    e = m_read(ad);
    @(negedge clk);
    bus_addr = AW'(ad); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(req, bus_rdata, e);
  endtask

  task automatic rdwr(int ad, logic [15:0] d, string req);
    logic [15:0] e;
    e = m_read(ad);
    @(negedge clk);
    bus_addr = AW'(ad); bus_wdata = d; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    m_write(ad, d);
    check(req, bus_rdata, e);
  endtask

  task automatic rd_all16(string req);
    for (int k = 4; k <= 7; k++) rd(k, req);
  endtask

  task automatic rd_all64(string req);
    for (int k = 13; k <= 16; k++) rd(k, req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_reset();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    m_reset();
    do_reset();

    // R10: reset state
    check("R10 rdata after reset", bus_rdata, 16'h0);
    for (int k = 0; k <= 17; k++) rd(k, "R10 reset value");

    // R1 R3 R4: unsigned and signed products
    wr(0, 16'hFFFF); rd(0, "R1 operand A readback");
    wr(4, 16'hFFFF); rd_all16("R3 unsigned product max");
    wr(1, 16'h8000); wr(4, 16'h8000); rd_all16("R4 signed 0x8000 squared");
    wr(1, 16'hFFFF); wr(4, 16'h0002); rd_all16("R4 signed negative product");
    rd(7, "R5 signed product negative sumext");
    // R5: unsigned product sumext zero even with top bit set
    wr(0, 16'hFFFF); wr(4, 16'hFFFF); rd(7, "R5 unsigned sumext zero");

    // R3 R6: accumulate with preload and wrap
    wr(2, 16'hFFFF); wr(5, 16'hFFFF); rd_all16("R6 unsigned preload zext");
    wr(4, 16'hFFFF); wr(4, 16'hFFFF); rd_all16("R3 unsigned accumulate");
    wr(3, 16'h7FFF); wr(5, 16'h8000); rd_all16("R6 signed preload sext");
    wr(4, 16'hFFFF); rd_all16("R3 signed accumulate");
    rd(7, "R5 signed accumulate sumext");
    wr(5, 16'hFFFF); wr(4, 16'h0001); rd(7, "R5 signed accumulate crosses zero");
    // R3: product mode after accumulate clears accumulator
    wr(0, 16'h0003); wr(4, 16'h0005); wr(3, 16'h0001); wr(4, 16'h0001);
    rd_all16("R3 accumulator cleared by product");

    // R2: result visible on read right after trigger; rdata holds without read
    wr(1, 16'h1234); wr(4, 16'h0010); rd(5, "R2 next-cycle result");
    held = m_read(5);
    @(negedge clk); @(negedge clk);
    check("R2 rdata hold", bus_rdata, held);

    // R7 R8: wide section
    wr(8, 16'hFFFF); wr(10, 16'hFFFF); wr(11, 16'hFFFF); wr(12, 16'hFFFF);
    rd_all64("R8 unsigned 64 max");
    for (int k = 8; k <= 12; k++) rd(k, "R7 wide operand readback");
    wr(11, 16'h0003); rd_all64("R8 low half of B no trigger");
    rd(12, "R7 low write clears B high");
    wr(9, 16'h0002); rd(10, "R7 low write clears A high");
    wr(10, 16'h8000); rd(9, "R7 high merge keeps low");
    wr(12, 16'h0001); rd_all64("R8 signed 64 negative");
    wr(10, 16'h8000); wr(8, 16'h0000); wr(10, 16'h8000); wr(9, 16'h0000); wr(10, 16'h8000);
    wr(11, 16'h0000); wr(12, 16'h8000); rd_all64("R8 signed min squared");

    // R9: unmapped read and writes to read-only offsets
    rd(17, "R9 unmapped read"); rd(31, "R9 unmapped read top");
    wr(6, 16'hAAAA); wr(7, 16'h5555); wr(13, 16'h1111); wr(16, 16'h2222); wr(20, 16'h3333);
    rd_all16("R9 read-only write ignored"); rd_all64("R9 read-only write ignored");

    // R11: same-cycle read and write
    wr(3, 16'h0004);
    rdwr(5, 16'hFFF0, "R11 preload read old"); rd_all16("R11 preload took effect");
    rdwr(4, 16'h0007, "R11 trigger read old B"); rd_all16("R11 trigger took effect");
    rdwr(12, 16'h0002, "R11 wide trigger read old"); rd_all64("R11 wide trigger took effect");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      logic [15:0] d;
      sel = int'($urandom_range(0, 12));
      d = 16'($urandom);
      if (($urandom & 7) == 0) d = (($urandom & 1) != 0) ? 16'h8000 : 16'hFFFF;
      wr(sel, d);
      if (sel == 4 || sel == 5) rd_all16("R3 random narrow");
      if (sel == 12) rd_all64("R8 random wide");
      if ((it % 16) == 0) rd(int'($urandom_range(0, 20)), "R1 random readback");
    end

    // R10: reset mid-run
    do_reset();
    rd_all16("R10 reset clears narrow"); rd_all64("R10 reset clears wide");
    rd(0, "R10 reset clears operand");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule